// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets each of `NumCores` cores raise an interrupt on any other core through one shared command port. A command names the issuing core, an operation code and a core-number argument. Each core has one interrupt line. The line stays high while at least one sender has an interrupt outstanding towards that core. Two read operations place their result in a shared readback register: one asks whether a target is busy, the other asks who is calling the issuing core.

When several cores signal the same target, their requests fold into a single raised line. The receiver fetches a bitmask of callers and retires them one at a time with an acknowledge that names a single caller. A core cannot signal itself through this unit. Such a request is dropped. Arbitration between cores for the command port is done outside the block, so at most one command arrives per cycle.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every interrupt line is low and the readback register reads zero.
- R2: A raise command (op code 0) from core c with argument t, where t differs from c, records c as a caller of t, and `irqOut[t]` is high in the next cycle.
- R3: A raise command (op code 0) whose argument equals the issuing core has no effect on any interrupt line or caller record.
- R4: A peek command (op code 1) with argument t loads the readback register in the next cycle with 1 if t has any caller recorded, and with 0 otherwise.
- R5: Raise commands from different cores to the same target merge into one asserted line on that target.
- R6: A who command (op code 2) loads the readback register in the next cycle with the issuing core's caller mask, bit k set when core k (weight 2^k) is a recorded caller.
- R7: An acknowledge command (op code 3) from core c with argument s clears only caller s in c's record. `irqOut[c]` drops in the cycle after the last caller is cleared.
- R8: A raise from a caller that is already recorded for that target leaves all state unchanged.
- R9: The readback register changes only on the cycle after a peek or who command. It holds its value across idle cycles, raises and acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdCore | input | CoreW | Number of the core issuing the command |
| cmdOp | input | 2 | Operation: 0 raise, 1 peek, 2 who, 3 acknowledge |
| cmdArg | input | CoreW | Core-number argument (target or caller) |
| rdData | output | NumCores | Readback register |
| irqOut | output | NumCores | One interrupt line per core |

## Verification
A wrong caller record shows up in two places. It appears on the affected interrupt line one cycle after the command that should have set or cleared it. It also appears in the readback register one cycle after a peek or who command addressed to that core. Folding several callers into one line, retiring them one at a time, and dropping self-raises and repeated raises are each followed at once by reads. A corrupted bit therefore reaches the ports within two cycles. The reference model is compared with both outputs on every clock, so a readback that changes when it should hold is caught on the first idle cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    OP_RAISE = 2'd0,
    OP_PEEK  = 2'd1,
    OP_WHO   = 2'd2,
    OP_CLEAR = 2'd3
  } ipiOp_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic raise;
    logic clear;
    logic peek;
    logic who;
  } ipiStrb_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NumCores = 4,
  parameter int CoreW    = $clog2(NumCores)
) (
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [CoreW-1:0] cmdCore,
  input  logic [CoreW-1:0] cmdArg,
  output ipiStrb_t         strb
);
  localparam logic [CoreW:0] LastCore = (CoreW+1)'(NumCores - 1);

  logic inRange;
  logic selfTarget;

  always_comb begin
    inRange    = ({1'b0, cmdCore} <= LastCore) && ({1'b0, cmdArg} <= LastCore);
    selfTarget = (cmdCore == cmdArg);
    strb       = '0;
    if (cmdValid && inRange) begin
      unique case (ipiOp_e'(cmdOp))
        OP_RAISE: strb.raise = !selfTarget;
        OP_PEEK:  strb.peek  = 1'b1;
        OP_WHO:   strb.who   = 1'b1;
        OP_CLEAR: strb.clear = 1'b1;
        default:  strb       = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NumCores = 4,
  parameter int CoreW    = $clog2(NumCores)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ipiStrb_t            strb,
  input  logic [CoreW-1:0]    cmdCore,
  input  logic [CoreW-1:0]    cmdArg,
  output logic [NumCores-1:0] rdData,
  output logic [NumCores-1:0] irqOut
);
  // callerRow[t][s] set: core s has an interrupt outstanding towards core t
  logic [NumCores-1:0] callerRow [NumCores];

  for (genvar t = 0; t < NumCores; t++) begin : g_target
    always_ff @(posedge clk) begin
      if (!rstN) begin
        callerRow[t] <= '0;
      end else begin
        if (strb.raise && (cmdArg == CoreW'(t)))
          callerRow[t][cmdCore] <= 1'b1;
        if (strb.clear && (cmdCore == CoreW'(t)))
          callerRow[t][cmdArg] <= 1'b0;
      end
    end
    assign irqOut[t] = |callerRow[t];
  end

  logic [NumCores-1:0] peekWord;
  assign peekWord = {{(NumCores-1){1'b0}}, |callerRow[cmdArg]};

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strb.peek)
      rdData <= peekWord;
    else if (strb.who)
      rdData <= callerRow[cmdCore];
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NumCores = 4,
  parameter int CoreW    = $clog2(NumCores)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [CoreW-1:0]    cmdCore,
  input  logic [1:0]          cmdOp,
  input  logic [CoreW-1:0]    cmdArg,
  output logic [NumCores-1:0] rdData,
  output logic [NumCores-1:0] irqOut
);
  ipiStrb_t strb;

  ipi_ctrl #(.NumCores(NumCores), .CoreW(CoreW)) u_ctrl (
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdCore (cmdCore),
    .cmdArg  (cmdArg),
    .strb    (strb)
  );

  ipi_datapath #(.NumCores(NumCores), .CoreW(CoreW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cmdCore(cmdCore),
    .cmdArg (cmdArg),
    .rdData (rdData),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
  parameter int NumCores = 4,
  parameter int CoreW    = $clog2(NumCores)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [CoreW-1:0]    cmdCore,
  input logic [1:0]          cmdOp,
  input logic [CoreW-1:0]    cmdArg,
  input logic [NumCores-1:0] rdData,
  input logic [NumCores-1:0] irqOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqOut == '0) && (rdData == '0));

  // R2
  raise_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0 && cmdArg != cmdCore) |=> irqOut[$past(cmdArg)]);

  // R3
  self_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0 && cmdArg == cmdCore) |=> $stable(irqOut));

  // R4
  peek_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1) |=> rdData == NumCores'($past(irqOut[cmdArg])));

  // R6
  who_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd2) |=> ((rdData != '0) == $past(irqOut[cmdCore])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> $stable(irqOut) && $stable(rdData));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 2'd0 || cmdOp == 2'd3)) |=> $stable(rdData));
endmodule

bind ipi_unit ipi_unit_chk #(.NumCores(NumCores), .CoreW(CoreW)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCore(cmdCore),
  .cmdOp(cmdOp), .cmdArg(cmdArg), .rdData(rdData), .irqOut(irqOut)
);

// File: tb/test_ipi_unit.sv
module test_ipi_unit;
  localparam int ClkPeriod = 10;
  localparam int N = 4;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [W-1:0] cmdCore = '0;
  logic [1:0] cmdOp = '0;
  logic [W-1:0] cmdArg = '0;
  logic [N-1:0] rdData;
  logic [N-1:0] irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curTag = "R1";

  // reference state: refCallers[t][s] = core s is calling core t
  bit [N-1:0] refCallers [N];
  bit [N-1:0] refRd;

  always #(ClkPeriod/2) clk = ~clk;

  ipi_unit #(.NumCores(N)) i_ipi_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCore(cmdCore),
    .cmdOp(cmdOp), .cmdArg(cmdArg), .rdData(rdData), .irqOut(irqOut)
  );

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      foreach (refCallers[i]) refCallers[i] = '0;
      refRd = '0;
    end else if (cmdValid) begin
      int c;
      int a;
      c = cmdCore;
      a = cmdArg;
      case (cmdOp)
        2'd0: if (c != a) refCallers[a][c] = 1'b1;
        2'd1: refRd = (refCallers[a] != 0) ? N'(1) : N'(0);
        2'd2: refRd = refCallers[c];
        default: refCallers[c][a] = 1'b0;
      endcase
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (!finished) begin
      bit [N-1:0] expIrq;
      for (int t = 0; t < N; t++) expIrq[t] = (refCallers[t] != 0);
      total++;
      if (irqOut !== expIrq || rdData !== refRd) begin
        bad++;
        $display("FAIL %s irqOut=%b exp=%b rdData=%b exp=%b",
                 curTag, irqOut, expIrq, rdData, refRd);
      end
    end
  end

  task automatic issue(input int core, input int op, input int arg, input string tag);
    @(posedge clk);
    #1;
    curTag   = tag;
    cmdValid = 1'b1;
    cmdCore  = W'(core);
    cmdOp    = 2'(op);
    cmdArg   = W'(arg);
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    curTag = tag;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(2, "R1");
    issue(0, 0, 2, "R2");        // core0 calls core2
    issue(1, 1, 2, "R4");        // peek busy target -> 1
    issue(1, 1, 3, "R4");        // peek quiet target -> 0
    issue(1, 0, 1, "R3");        // self raise dropped
    issue(0, 1, 1, "R3");        // core1 still quiet
    issue(3, 0, 2, "R5");
    issue(3, 0, 2, "R8");        // repeat raise
    issue(1, 0, 2, "R5");
    issue(2, 2, 0, "R6");        // callers of core2 = 1011
    idle(3, "R9");
    issue(2, 3, 3, "R7");        // retire caller 3 only
    issue(2, 2, 0, "R7");        // -> 0011
    issue(2, 3, 0, "R7");
    issue(0, 0, 3, "R9");        // readback holds across raise
    issue(2, 3, 1, "R7");        // last caller of core2 gone
    issue(2, 2, 0, "R7");        // -> 0000
    issue(2, 0, 0, "R2");
    issue(3, 0, 1, "R2");
    issue(0, 2, 0, "R6");        // callers of core0 = 0100
    issue(3, 2, 0, "R6");        // callers of core3 = 0001
    issue(0, 3, 2, "R7");        // retire 2 on core0, core3 untouched
    issue(3, 3, 1, "R7");        // no such caller, harmless
    issue(1, 2, 0, "R6");        // callers of core1 = 1000
    idle(2, "R9");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule